// File: doc/BRIEF.md
# Variable-Length SPI Serial Engine

This block moves one data word of 8 to 16 bits over a synchronous four-wire serial link per transfer. It acts as the clock-generating side (master) or as the clock-following side (slave), chosen by a static configuration input. Clock polarity and clock phase are selectable, so the block can talk to any of the four common SPI timing variants. The data is shifted most significant bit first.

The word length comes from a 4-bit length code. Code 0 selects 16 bits. Codes 8 to 15 select the same number of bits. Codes 1 to 7 are unused and fall back to 8 bits. In master mode a length-enable flag that travels with each command chooses between the code and a fixed 8 bits. In slave mode only the code counts.

In master mode a pulse on `start` launches a transfer of `tx_word`. The block asserts its select line, generates the serial clock from the system clock with an 8-bit modulus divider, and raises `done` for one cycle with the received word on `rx_word`. In slave mode the block follows an external clock and select line. It reports each completed word through the same `done`/`rx_word` pair and reloads `tx_word` for the next word. Configuration must be held stable while a transfer is running.

Top module: `spi_xfer_engine`

## Requirements
- R1: The length code maps 4'b0000 to 16 bits and each code 4'b1000..4'b1111 to 8..15 bits (code value as the count).
- R2: Length codes 4'b0001..4'b0111 produce 8-bit transfers in both modes.
- R3: In master mode with `cfg_len_en` = 0, a transfer has exactly 8 bits (16 SCK edges) whatever the length code.
- R4: In slave mode `cfg_len_en` has no effect: the word is stored after the number of bits the length code selects.
- R5: With `cfg_cpol` = 0 the master SCK rests low, with `cfg_cpol` = 1 it rests high, outside transfers and on the done cycle.
- R6: With `cfg_cpha` = 0 data is captured on leading SCK edges and changed on trailing edges. The first data bit is on the data output as soon as the select line is asserted, before the first SCK edge.
- R7: With `cfg_cpha` = 1 data is changed on leading SCK edges and captured on trailing edges.
- R8: In master mode every SCK half-period lasts `cfg_div` system clocks. Divider values 0 and 1 behave as 2.
- R9: Words are right-justified in 16 bits and sent MSB first. An N-bit transfer sends `tx_word[N-1:0]` and returns the received bits in `rx_word[N-1:0]` with the upper bits zero.
- R10: In master mode `ss_n_o` is low from the cycle after `start` until the final SCK edge. `done` is a one-cycle pulse in the cycle after the final edge, in which `ss_n_o` is high again.
- R11: In slave mode, after the selected number of bits has been captured while `ss_n_i` is low, `done` pulses once with the word on `rx_word`. `miso_o` shifts out `tx_word` MSB first during the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_cpol | input | 1 | SCK resting level |
| cfg_cpha | input | 1 | 0 = capture on leading edge, 1 = capture on trailing edge |
| cfg_len_code | input | 4 | Word length code |
| cfg_len_en | input | 1 | Master only: 1 = use length code, 0 = 8 bits |
| cfg_div | input | 8 | Master SCK half-period in system clocks |
| start | input | 1 | Master: launch a transfer (ignored while busy) |
| tx_word | input | 16 | Word to send, right-justified |
| busy | output | 1 | Transfer in progress (master) or select active (slave) |
| done | output | 1 | One-cycle pulse when a word is complete |
| rx_word | output | 16 | Last received word, right-justified |
| sck_o | output | 1 | Master serial clock |
| ss_n_o | output | 1 | Master select, active low |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Slave serial clock |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |

## Verification
With clock phase 1, the master's last capture, the latching of `rx_word`, the return of SCK to rest and the release of the select line all fall in the same clock edge. With phase 0 the last capture comes one half-period earlier, and only the closing trailing edge coincides with `done`. The bench runs transfers in both phases and with the smallest divider, so these events land together. It judges them by sampling `rx_word`, `sck_o` and `ss_n_o` in the done cycle against a behavioural slave that records every MOSI bit at its own capture edges. In slave mode, the store of a finished word and the reload of the transmit word coincide on the final capture. The bench checks this through the received word and the MISO bit stream.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int DATA_W = 16;
  localparam int LEN_W  = $clog2(DATA_W + 1);
  localparam int CODE_W = 4;
  localparam int DIV_W  = 8;

  // Resolved word length: code 0 -> 16, 8..15 -> itself, 1..7 -> 8.
  function automatic logic [LEN_W-1:0] word_len(input logic [CODE_W-1:0] code,
                                                input logic use_code);
    logic [LEN_W-1:0] n;
    if (!use_code)            n = LEN_W'(8);
    else if (code == '0)      n = LEN_W'(DATA_W);
    else if (code[CODE_W-1])  n = LEN_W'(code);
    else                      n = LEN_W'(8);
    return n;
  endfunction
endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    div_eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;
    tick    = run && (cnt_q == div_eff - DIV_W'(1));
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  half_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div_eff));
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [CODE_W-1:0] cfg_len_code,
  input  logic              cfg_len_en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              ss_n_o,
  output logic              mosi_o,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int EDGE_W = LEN_W + 1;

  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic              cpol_q, cpol_d;
  logic              cpha_q, cpha_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [LEN_W-1:0]  bits_q, bits_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] rxw_q, rxw_d;
  logic              done_q, done_d;
  logic              tick;
  logic              is_sample;
  logic              last_edge;
  logic [3:0]        msb_idx;

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .div  (div_q),
    .tick (tick)
  );

  assign is_sample = (~edge_q[0]) ^ cpha_q;
  assign last_edge = (edge_q == EDGE_W'({len_q, 1'b0} - EDGE_W'(1)));
  assign msb_idx   = 4'(len_q - LEN_W'(1));

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    cpol_d = cpol_q;
    cpha_d = cpha_q;
    len_d  = len_q;
    div_d  = div_q;
    edge_d = edge_q;
    bits_d = bits_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    rxw_d  = rxw_q;
    done_d = 1'b0;
    if (!busy_q) begin
      sck_d = cfg_cpol;
      if (start && enable) begin
        busy_d = 1'b1;
        cpol_d = cfg_cpol;
        cpha_d = cfg_cpha;
        len_d  = word_len(cfg_len_code, cfg_len_en);
        div_d  = cfg_div;
        edge_d = '0;
        bits_d = '0;
        tx_d   = tx_word;
        rx_d   = '0;
      end
    end else if (tick) begin
      sck_d  = ~sck_q;
      edge_d = edge_q + EDGE_W'(1);
      if (is_sample) begin
        rx_d   = {rx_q[DATA_W-2:0], miso_i};
        bits_d = bits_q + LEN_W'(1);
      end else if (bits_q != '0) begin
        tx_d = tx_q << 1;
      end
      if (last_edge) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        rxw_d  = rx_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      len_q  <= LEN_W'(8);
      div_q  <= DIV_W'(2);
      edge_q <= '0;
      bits_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      rxw_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      cpol_q <= cpol_d;
      cpha_q <= cpha_d;
      len_q  <= len_d;
      div_q  <= div_d;
      edge_q <= edge_d;
      bits_q <= bits_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      rxw_q  <= rxw_d;
      done_q <= done_d;
    end
  end

  assign sck_o   = sck_q;
  assign ss_n_o  = ~busy_q;
  assign mosi_o  = tx_q[msb_idx];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rxw_q;

  // R10
  m_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R5
  m_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (sck_q == cpol_q) && !busy_q);
  // R10
  m_edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (edge_q < EDGE_W'({len_q, 1'b0})));
  // R9
  m_rx_justify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((32'(rxw_q) >> len_q) == 32'd0));
endmodule

// File: rtl/spi_slave_core.sv
module spi_slave_core
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [CODE_W-1:0] cfg_len_code,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  logic sck_m, sck_s, sck_p;
  logic ss_m, ss_s, ss_p;
  logic mosi_m, mosi_s;

  logic [LEN_W-1:0]  len;
  logic [LEN_W-1:0]  bits_q, bits_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] rxw_q, rxw_d;
  logic [DATA_W-1:0] rx_new;
  logic              done_q, done_d;
  logic              sel_fall, sck_edge, leading, is_sample;
  logic [3:0]        msb_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= 1'b0; sck_s <= 1'b0; sck_p <= 1'b0;
      ss_m  <= 1'b1; ss_s  <= 1'b1; ss_p  <= 1'b1;
      mosi_m <= 1'b0; mosi_s <= 1'b0;
    end else begin
      sck_m <= sck_i;  sck_s <= sck_m;  sck_p <= sck_s;
      ss_m  <= ss_n_i; ss_s  <= ss_m;   ss_p  <= ss_s;
      mosi_m <= mosi_i; mosi_s <= mosi_m;
    end
  end

  assign len       = word_len(cfg_len_code, 1'b1);
  assign msb_idx   = 4'(len - LEN_W'(1));
  assign sel_fall  = ss_p && !ss_s;
  assign sck_edge  = !ss_p && !ss_s && (sck_s != sck_p);
  assign leading   = (sck_s != cfg_cpol);
  assign is_sample = leading ^ cfg_cpha;
  assign rx_new    = {rx_q[DATA_W-2:0], mosi_s};

  always_comb begin
    bits_d = bits_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    rxw_d  = rxw_q;
    done_d = 1'b0;
    if (sel_fall) begin
      bits_d = '0;
      tx_d   = tx_word;
      rx_d   = '0;
    end else if (sck_edge) begin
      if (is_sample) begin
        if (bits_q + LEN_W'(1) == len) begin
          rxw_d  = rx_new;
          done_d = 1'b1;
          bits_d = '0;
          rx_d   = '0;
          tx_d   = tx_word;
        end else begin
          bits_d = bits_q + LEN_W'(1);
          rx_d   = rx_new;
        end
      end else if (bits_q != '0) begin
        tx_d = tx_q << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      rxw_q  <= '0;
      done_q <= 1'b0;
    end else begin
      bits_q <= bits_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      rxw_q  <= rxw_d;
      done_q <= done_d;
    end
  end

  assign miso_o  = ss_s ? 1'b0 : tx_q[msb_idx];
  assign busy    = ~ss_s;
  assign done    = done_q;
  assign rx_word = rxw_q;

  // R11
  s_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R11
  s_bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q < len);
  // R9
  s_rx_justify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((32'(rxw_q) >> len) == 32'd0));
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [CODE_W-1:0] cfg_len_code,
  input  logic              cfg_len_en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck_o,
  output logic              ss_n_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o
);
  logic              rst_sync_n;
  logic              m_busy, m_done;
  logic [DATA_W-1:0] m_rx;
  logic              s_busy, s_done, s_miso;
  logic [DATA_W-1:0] s_rx;
  logic              s_sel_n;

  spi_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  spi_master_core u_master (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .enable      (cfg_master),
    .start       (start),
    .cfg_cpol    (cfg_cpol),
    .cfg_cpha    (cfg_cpha),
    .cfg_len_code(cfg_len_code),
    .cfg_len_en  (cfg_len_en),
    .cfg_div     (cfg_div),
    .tx_word     (tx_word),
    .miso_i      (miso_i),
    .sck_o       (sck_o),
    .ss_n_o      (ss_n_o),
    .mosi_o      (mosi_o),
    .busy        (m_busy),
    .done        (m_done),
    .rx_word     (m_rx)
  );

  assign s_sel_n = cfg_master | ss_n_i;

  spi_slave_core u_slave (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_cpol    (cfg_cpol),
    .cfg_cpha    (cfg_cpha),
    .cfg_len_code(cfg_len_code),
    .tx_word     (tx_word),
    .sck_i       (sck_i),
    .ss_n_i      (s_sel_n),
    .mosi_i      (mosi_i),
    .miso_o      (s_miso),
    .busy        (s_busy),
    .done        (s_done),
    .rx_word     (s_rx)
  );

  assign busy    = cfg_master ? m_busy : s_busy;
  assign done    = cfg_master ? m_done : s_done;
  assign rx_word = cfg_master ? m_rx   : s_rx;
  assign miso_o  = cfg_master ? 1'b0   : s_miso;
endmodule

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SLV   = 8;

  logic        clk, rst_n;
  logic        cfg_master, cfg_cpol, cfg_cpha, cfg_len_en;
  logic [3:0]  cfg_len_code;
  logic [7:0]  cfg_div;
  logic        start;
  logic [15:0] tx_word;
  logic        busy, done;
  logic [15:0] rx_word;
  logic        sck_o, ss_n_o, mosi_o, miso_i;
  logic        sck_i, ss_n_i, mosi_i, miso_o;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  bit          tb_master;
  bit          cur_cpol, cur_cpha;
  int          exp_n, exp_d;
  logic [15:0] slv_word;
  int          cnt, edges, samples, timing_err, pin_err, done_cnt;
  logic [15:0] mosi_cap, rx_at_done;
  logic        sck_at_done, ss_at_done;
  logic        prev_sck, prev_ss;

  spi_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_len_code(cfg_len_code), .cfg_len_en(cfg_len_en),
    .cfg_div(cfg_div), .start(start), .tx_word(tx_word), .busy(busy),
    .done(done), .rx_word(rx_word), .sck_o(sck_o), .ss_n_o(ss_n_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i), .ss_n_i(ss_n_i),
    .mosi_i(mosi_i), .miso_o(miso_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mask_of(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference slave (master mode) and done recorder, evaluated every clock.
  always @(negedge clk) begin
    if (!rst_n) begin
      miso_i   = 1'b0;
      prev_sck = 1'b0;
      prev_ss  = 1'b1;
    end else begin
      if (tb_master) begin
        if (prev_ss && !ss_n_o) begin
          cnt = 1; edges = 0; samples = 0; mosi_cap = '0;
          miso_i = slv_word[exp_n-1];
          if (!cur_cpha && mosi_o !== tx_word[exp_n-1]) pin_err++;
          if (sck_o !== cur_cpol) pin_err++;
        end else if (!prev_ss || !ss_n_o) begin
          if (sck_o != prev_sck) begin
            if (cnt != exp_d) timing_err++;
            cnt = 1;
            edges++;
            if ((sck_o != cur_cpol) ^ cur_cpha) begin
              mosi_cap = {mosi_cap[14:0], mosi_o};
              samples++;
            end else if (samples > 0 && samples < exp_n) begin
              miso_i = slv_word[exp_n-1-samples];
            end
          end else begin
            cnt++;
          end
        end
      end
      if (done) begin
        done_cnt++;
        rx_at_done  = rx_word;
        sck_at_done = sck_o;
        ss_at_done  = ss_n_o;
      end
      prev_sck = sck_o;
      prev_ss  = ss_n_o;
    end
  end

  task automatic run_master(input logic [3:0] code, input logic en,
                            input logic cpol, input logic cpha,
                            input logic [7:0] div, input logic [15:0] txw,
                            input logic [15:0] slw, input int n,
                            input string tag);
    int g;
    @(negedge clk);
    tb_master = 1; cfg_master = 1'b1;
    cfg_len_code = code; cfg_len_en = en; cfg_cpol = cpol; cfg_cpha = cpha;
    cfg_div = div; tx_word = txw;
    cur_cpol = cpol; cur_cpha = cpha; exp_n = n;
    exp_d = (div < 2) ? 2 : int'(div);
    slv_word = slw; done_cnt = 0; timing_err = 0; pin_err = 0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    g = 0;
    while (done_cnt == 0 && g < 20000) begin @(negedge clk); g++; end
    chk(done_cnt == 1, tag, "done pulses (R10)", done_cnt, 1);
    chk(edges == 2*n, tag, "SCK edges = 2*length", edges, 2*n);
    chk(timing_err == 0, tag, "half-period length (R8)", timing_err, 0);
    chk(pin_err == 0, cpha ? tag : "R6", "levels at select", pin_err, 0);
    chk(mosi_cap == (txw & mask_of(n)), tag, "MOSI bits MSB first (R9)",
        mosi_cap, txw & mask_of(n));
    chk(rx_at_done == (slw & mask_of(n)), tag, "rx_word at done (R9)",
        rx_at_done, slw & mask_of(n));
    chk(sck_at_done == cpol && ss_at_done == 1'b1, tag,
        "SCK rest and select released at done (R10)",
        {sck_at_done, ss_at_done}, {cpol, 1'b1});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(sck_o == cpol && ss_n_o && !done, "R5", "idle pins after done",
          {sck_o, ss_n_o, done}, {cpol, 2'b10});
    end
  endtask

  task automatic run_slave(input logic [3:0] code, input logic en,
                           input logic cpol, input logic cpha,
                           input logic [15:0] txw, input logic [15:0] mw,
                           input int n, input string tag);
    logic [15:0] mcap;
    @(negedge clk);
    tb_master = 0; cfg_master = 1'b0;
    cfg_len_code = code; cfg_len_en = en; cfg_cpol = cpol; cfg_cpha = cpha;
    tx_word = txw; sck_i = cpol; ss_n_i = 1'b1; mosi_i = 1'b0;
    repeat (4) @(negedge clk);
    done_cnt = 0; mcap = '0;
    ss_n_i = 1'b0;
    if (!cpha) mosi_i = mw[n-1];
    repeat (HALF_SLV) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (!cpha) begin
        mcap = {mcap[14:0], miso_o};
        sck_i = ~cpol;
        repeat (HALF_SLV) @(negedge clk);
        sck_i = cpol;
        if (i < n-1) mosi_i = mw[n-2-i];
        repeat (HALF_SLV) @(negedge clk);
      end else begin
        mosi_i = mw[n-1-i];
        sck_i = ~cpol;
        repeat (HALF_SLV) @(negedge clk);
        mcap = {mcap[14:0], miso_o};
        sck_i = cpol;
        repeat (HALF_SLV) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, tag, "slave done pulses (R11)", done_cnt, 1);
    chk(rx_at_done == (mw & mask_of(n)), tag, "slave rx_word (R11)",
        rx_at_done, mw & mask_of(n));
    chk(mcap == (txw & mask_of(n)), tag, "slave MISO bits (R11)",
        mcap, txw & mask_of(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tb_master = 1; rst_n = 1'b0; cfg_master = 1'b1; cfg_cpol = 1'b0;
    cfg_cpha = 1'b0; cfg_len_code = 4'h0; cfg_len_en = 1'b1; cfg_div = 8'd2;
    start = 1'b0; tx_word = '0; sck_i = 1'b0; ss_n_i = 1'b1; mosi_i = 1'b0;
    slv_word = '0; exp_n = 8; exp_d = 2; cur_cpol = 0; cur_cpha = 0;
    done_cnt = 0; cnt = 0; edges = 0; samples = 0; timing_err = 0; pin_err = 0;
    mosi_cap = '0; rx_at_done = '0; sck_at_done = 0; ss_at_done = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state (R5, R10)
    chk(!busy && !done && ss_n_o && rx_word == 16'h0 && sck_o == 1'b0,
        "R10", "reset state", {busy, done, ss_n_o, sck_o}, 4'b0010);

    run_master(4'b0000, 1'b1, 1'b0, 1'b0, 8'd2, 16'hA5C3, 16'h3C96, 16, "R1");
    run_master(4'b1011, 1'b1, 1'b1, 1'b1, 8'd3, 16'h05B7, 16'h0629, 11, "R7");
    run_master(4'b0011, 1'b1, 1'b0, 1'b1, 8'd5, 16'hFF5A, 16'h00C3, 8, "R2");
    run_master(4'b1111, 1'b0, 1'b1, 1'b0, 8'd0, 16'h1E81, 16'h77A4, 8, "R3");
    run_master(4'b1000, 1'b1, 1'b0, 1'b0, 8'd1, 16'h00D2, 16'h004B, 8, "R8");
    run_master(4'b1101, 1'b1, 1'b0, 1'b0, 8'd4, 16'h1ACE, 16'h0B71, 13, "R6");
    run_master(4'b1110, 1'b1, 1'b1, 1'b1, 8'd2, 16'h2F0F, 16'h1234, 14, "R9");

    run_slave(4'b1100, 1'b0, 1'b0, 1'b0, 16'h0A5C, 16'h0B3E, 12, "R4");
    run_slave(4'b0000, 1'b0, 1'b1, 1'b1, 16'hC3A5, 16'h5A69, 16, "R11");
    run_slave(4'b0101, 1'b1, 1'b0, 1'b1, 16'h00B4, 16'h0097, 8, "R2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule